// File: doc/BRIEF.md
# Fetch Redirect Arbiter with Epochs

This block is the PC selection stage at the front of a pipeline in which both the decode stage and the execute stage may steer instruction fetch onto a new path. It holds the fetch PC and two one-bit tags. The first tag is fetch's guess at the execute stage's current path tag. The second is its guess at the decode stage's path tag. Each cycle it makes one choice. It can take an execute correction, apply or discard a decode correction, or send a fetch packet toward decode.

Execute messages arrive for every resolved control instruction. They are always accepted and are passed straight on to the next-address predictor as training. Only those flagged as mispredicted move the PC. A decode correction carries the execute tag it was produced under. If that tag differs from fetch's current guess, the correction came from a wrong-path instruction and is consumed without effect. The predictor appears as a lookup port: the block presents its PC, and the predictor returns a hit flag and a target.

Each cycle the block takes one of five actions, chosen by fixed priority:
- ACT_EX_REDIR: an execute mispredict is present.
- ACT_DC_APPLY: a decode correction is present and its tag matches.
- ACT_DC_DROP: a decode correction is present and its tag does not match.
- ACT_FETCH: a packet is accepted downstream.
- ACT_STALL: a packet is offered but not accepted.

The action applies one transition to the registered state:
- ACT_EX_REDIR loads the execute target into the PC and inverts the execute tag.
- ACT_DC_APPLY loads the decode target into the PC and inverts the decode tag.
- ACT_FETCH loads the predicted PC into the PC.
- ACT_DC_DROP and ACT_STALL hold the state.

Top module: `fetch_redirect_arb`

## Requirements
- R1: Reset state. While rst_n is low and in the first cycle after it, the PC is RESET_PC and both tag outputs (fp_ex_epoch, fp_dc_epoch) are 0.
- R2: Execute messages are never blocked. ex_ready is always 1. Whenever ex_valid is 1, trn_valid is 1 and trn_pc, trn_target, trn_taken and trn_mispredict equal the execute inputs in the same cycle.
- R3: When ex_valid and ex_mispredict are both 1, the PC takes ex_next_pc in the next cycle and fp_ex_epoch inverts. fp_dc_epoch is unchanged.
- R4: An execute message with ex_mispredict at 0 changes neither the PC nor either tag. The rest of the cycle proceeds as if that message were absent.
- R5: Priority. When an execute mispredict and dc_valid fall in the same cycle, dc_ready is 0 and the decode correction has no effect. The correction stays pending and is judged in the next cycle against the updated execute tag.
- R6: When dc_valid is 1, no execute mispredict is present, and dc_ex_epoch equals fp_ex_epoch, then dc_ready is 1. The PC takes dc_target in the next cycle and fp_dc_epoch inverts.
- R7: When dc_valid is 1, no execute mispredict is present, and dc_ex_epoch differs from fp_ex_epoch, then dc_ready is 1. The PC and both tags are unchanged in the next cycle.
- R8: fp_valid is 0 in any cycle that has an execute mispredict or dc_valid at 1.
- R9: Otherwise fp_valid is 1 and the packet carries fp_pc (the current PC), fp_ppc, fp_ex_epoch and fp_dc_epoch. When fp_ready is 1, the PC becomes fp_ppc in the next cycle.
- R10: fp_ppc equals pred_target when pred_hit is 1, and pc+INSTR_BYTES otherwise. pred_pc always shows the current PC.
- R11: While fp_valid is 1 and fp_ready is 0, the PC and both tags hold, and the packet is offered again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_valid | input | 1 | Execute message present |
| ex_ready | output | 1 | Execute message accepted (always 1) |
| ex_pc | input | ADDR_W | PC of the resolved control instruction |
| ex_next_pc | input | ADDR_W | Resolved next PC |
| ex_taken | input | 1 | Resolved direction |
| ex_mispredict | input | 1 | Prediction was wrong; redirect |
| dc_valid | input | 1 | Decode correction present |
| dc_ready | output | 1 | Decode correction consumed |
| dc_ex_epoch | input | 1 | Execute tag the correction was produced under |
| dc_target | input | ADDR_W | Decode-computed next PC |
| pred_pc | output | ADDR_W | PC presented to the next-address predictor |
| pred_hit | input | 1 | Predictor has a target for pred_pc |
| pred_target | input | ADDR_W | Predicted next PC |
| trn_valid | output | 1 | Training message to predictor |
| trn_pc | output | ADDR_W | Training instruction PC |
| trn_target | output | ADDR_W | Training resolved next PC |
| trn_taken | output | 1 | Training direction |
| trn_mispredict | output | 1 | Training mispredict flag |
| fp_valid | output | 1 | Fetch packet offered |
| fp_ready | input | 1 | Fetch packet accepted |
| fp_pc | output | ADDR_W | Current fetch PC |
| fp_ppc | output | ADDR_W | Predicted next PC |
| fp_ex_epoch | output | 1 | Execute tag guess |
| fp_dc_epoch | output | 1 | Decode tag guess |

## Verification
An execute mispredict and a pending decode correction can fall in the same cycle. The bench forces this with directed cycles and with random overlap. It holds the decode correction across the following cycle to confirm two things: first that dc_ready stays low while execute wins, and then that the correction is judged against the freshly inverted execute tag. A second overlap is a non-mispredicted execute message alongside a decode correction or a fetch; there the training output must fire while the other action still takes effect. Each cycle a bench model computes the expected action and next state from the requirements. The port values are compared against that model before the clock edge.

// File: rtl/fra_pkg.sv
package fra_pkg;
    typedef enum logic [2:0] {
        ACT_FETCH    = 3'd0,
        ACT_STALL    = 3'd1,
        ACT_EX_REDIR = 3'd2,
        ACT_DC_APPLY = 3'd3,
        ACT_DC_DROP  = 3'd4
    } fra_act_e;
endpackage

// File: rtl/fra_next_pc.sv
module fra_next_pc #(
    parameter int ADDR_W      = 32,
    parameter int INSTR_BYTES = 4
) (
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic              hit,
    input  logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] next_pc
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

    always_comb begin
        next_pc = hit ? target : cur_pc + STEP;
    end
endmodule

// File: rtl/fra_decider.sv
module fra_decider
    import fra_pkg::*;
(
    input  logic     ex_redirect,
    input  logic     dc_valid,
    input  logic     dc_match,
    input  logic     fp_ready,
    output fra_act_e act
);
    always_comb begin
        if (ex_redirect)     act = ACT_EX_REDIR;
        else if (dc_valid)   act = dc_match ? ACT_DC_APPLY : ACT_DC_DROP;
        else if (fp_ready)   act = ACT_FETCH;
        else                 act = ACT_STALL;
    end
endmodule

// File: rtl/fetch_redirect_arb.sv
module fetch_redirect_arb
    import fra_pkg::*;
#(
    parameter int               ADDR_W      = 32,
    parameter int               INSTR_BYTES = 4,
    parameter logic [31:0]      RESET_PC    = 32'h0000_1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ex_valid,
    output logic              ex_ready,
    input  logic [ADDR_W-1:0] ex_pc,
    input  logic [ADDR_W-1:0] ex_next_pc,
    input  logic              ex_taken,
    input  logic              ex_mispredict,
    input  logic              dc_valid,
    output logic              dc_ready,
    input  logic              dc_ex_epoch,
    input  logic [ADDR_W-1:0] dc_target,
    output logic [ADDR_W-1:0] pred_pc,
    input  logic              pred_hit,
    input  logic [ADDR_W-1:0] pred_target,
    output logic              trn_valid,
    output logic [ADDR_W-1:0] trn_pc,
    output logic [ADDR_W-1:0] trn_target,
    output logic              trn_taken,
    output logic              trn_mispredict,
    output logic              fp_valid,
    input  logic              fp_ready,
    output logic [ADDR_W-1:0] fp_pc,
    output logic [ADDR_W-1:0] fp_ppc,
    output logic              fp_ex_epoch,
    output logic              fp_dc_epoch
);
    localparam logic [ADDR_W-1:0] PC_INIT = ADDR_W'(RESET_PC);

    logic [ADDR_W-1:0] pc_q;
    logic              ex_ep_q;
    logic              dc_ep_q;
    logic [ADDR_W-1:0] ppc;
    logic              ex_redirect;
    fra_act_e          act;

    assign ex_redirect = ex_valid && ex_mispredict;

    fra_next_pc #(.ADDR_W(ADDR_W), .INSTR_BYTES(INSTR_BYTES)) u_npc (
        .cur_pc (pc_q),
        .hit    (pred_hit),
        .target (pred_target),
        .next_pc(ppc)
    );

    fra_decider u_dec (
        .ex_redirect(ex_redirect),
        .dc_valid   (dc_valid),
        .dc_match   (dc_ex_epoch == ex_ep_q),
        .fp_ready   (fp_ready),
        .act        (act)
    );

    // State register: one transition per action
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= PC_INIT;
            ex_ep_q <= 1'b0;
            dc_ep_q <= 1'b0;
        end else begin
            unique case (act)
                ACT_EX_REDIR: begin
                    pc_q    <= ex_next_pc;
                    ex_ep_q <= ~ex_ep_q;
                end
                ACT_DC_APPLY: begin
                    pc_q    <= dc_target;
                    dc_ep_q <= ~dc_ep_q;
                end
                ACT_FETCH:    pc_q <= ppc;
                ACT_DC_DROP,
                ACT_STALL:    ;
                default:      ;
            endcase
        end
    end

    // Outputs decoded from the action
    always_comb begin
        fp_valid = 1'b0;
        dc_ready = 1'b0;
        unique case (act)
            ACT_EX_REDIR: ;
            ACT_DC_APPLY,
            ACT_DC_DROP:  dc_ready = 1'b1;
            ACT_FETCH,
            ACT_STALL:    fp_valid = 1'b1;
            default:      ;
        endcase
    end

    assign ex_ready       = 1'b1;
    assign trn_valid      = ex_valid;
    assign trn_pc         = ex_pc;
    assign trn_target     = ex_next_pc;
    assign trn_taken      = ex_taken;
    assign trn_mispredict = ex_mispredict;
    assign pred_pc        = pc_q;
    assign fp_pc          = pc_q;
    assign fp_ppc         = ppc;
    assign fp_ex_epoch    = ex_ep_q;
    assign fp_dc_epoch    = dc_ep_q;
endmodule

// File: rtl/fra_checker.sv
module fra_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ex_valid,
    input logic              ex_ready,
    input logic              ex_mispredict,
    input logic [ADDR_W-1:0] ex_next_pc,
    input logic              dc_valid,
    input logic              dc_ready,
    input logic              dc_ex_epoch,
    input logic [ADDR_W-1:0] dc_target,
    input logic              trn_valid,
    input logic              fp_valid,
    input logic              fp_ready,
    input logic [ADDR_W-1:0] fp_pc,
    input logic [ADDR_W-1:0] fp_ppc,
    input logic              fp_ex_epoch,
    input logic              fp_dc_epoch
);
    assert_ex_accepted_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ex_valid |-> (ex_ready && trn_valid));

    assert_ex_redirect_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_mispredict) |=>
            (fp_pc == $past(ex_next_pc)) && (fp_ex_epoch != $past(fp_ex_epoch))
            && $stable(fp_dc_epoch));

    assert_ex_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_mispredict) |-> !dc_ready);

    assert_dc_apply_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dc_valid && dc_ready && (dc_ex_epoch == fp_ex_epoch)) |=>
            (fp_pc == $past(dc_target)) && (fp_dc_epoch != $past(fp_dc_epoch)));

    assert_dc_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dc_valid && dc_ready && (dc_ex_epoch != fp_ex_epoch)) |=>
            $stable(fp_pc) && $stable(fp_ex_epoch) && $stable(fp_dc_epoch));

    assert_no_packet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((ex_valid && ex_mispredict) || dc_valid) |-> !fp_valid);

    assert_advance_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_valid && fp_ready) |=> (fp_pc == $past(fp_ppc)));

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_valid && !fp_ready) |=>
            $stable(fp_pc) && $stable(fp_ex_epoch) && $stable(fp_dc_epoch));
endmodule

bind fetch_redirect_arb fra_checker #(.ADDR_W(ADDR_W)) u_fra_chk (.*);

// File: tb/tb_fetch_redirect_arb.sv
module tb_fetch_redirect_arb;
    localparam int          CLK_PERIOD = 10;
    localparam int          AW         = 32;
    localparam logic [31:0] RST_PC     = 32'h0000_1000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ex_valid, ex_ready, ex_taken, ex_mispredict;
    logic [AW-1:0] ex_pc, ex_next_pc;
    logic          dc_valid, dc_ready, dc_ex_epoch;
    logic [AW-1:0] dc_target;
    logic [AW-1:0] pred_pc, pred_target;
    logic          pred_hit;
    logic          trn_valid, trn_taken, trn_mispredict;
    logic [AW-1:0] trn_pc, trn_target;
    logic          fp_valid, fp_ready, fp_ex_epoch, fp_dc_epoch;
    logic [AW-1:0] fp_pc, fp_ppc;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [AW-1:0] m_pc;
    logic          m_ee, m_de;

    always #(CLK_PERIOD/2) clk = ~clk;

    fetch_redirect_arb #(.ADDR_W(AW), .INSTR_BYTES(4), .RESET_PC(RST_PC)) dut (.*);

    function automatic logic [AW-1:0] exp_ppc(logic [AW-1:0] pc, logic hit, logic [AW-1:0] tgt);
        return hit ? tgt : pc + 32'd4;
    endfunction

    task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic drive(logic ev, logic em, logic [AW-1:0] enp, logic dv, logic dep,
                         logic [AW-1:0] dt, logic ph, logic [AW-1:0] pt, logic fr);
        ex_valid = ev; ex_mispredict = em; ex_next_pc = enp;
        ex_pc = $urandom() & 32'hFFFF_FFFC; ex_taken = $urandom_range(0, 1);
        dc_valid = dv; dc_ex_epoch = dep; dc_target = dt;
        pred_hit = ph; pred_target = pt; fp_ready = fr;
    endtask

    // Inputs were set at the falling edge; check, update model, advance one cycle
    task automatic step();
        logic exr, dcr, fpv;
        #1;
        exr = ex_valid && ex_mispredict;
        dcr = dc_valid && !exr;
        fpv = !exr && !dc_valid;
        chk("R2 ex_ready", ex_ready, 1);
        chk("R2 trn_valid", trn_valid, ex_valid);
        if (ex_valid) begin
            chk("R2 trn_pc", trn_pc, ex_pc);
            chk("R2 trn_target", trn_target, ex_next_pc);
            chk("R2 trn_flags", {trn_taken, trn_mispredict}, {ex_taken, ex_mispredict});
        end
        chk("R5 dc_ready", dc_ready, dcr);
        chk("R8 fp_valid", fp_valid, fpv);
        chk("R10 pred_pc", pred_pc, m_pc);
        chk("R9 fp_pc", fp_pc, m_pc);
        chk("R10 fp_ppc", fp_ppc, exp_ppc(m_pc, pred_hit, pred_target));
        chk("R9 epochs", {fp_ex_epoch, fp_dc_epoch}, {m_ee, m_de});
        if (exr) begin
            m_pc = ex_next_pc; m_ee = ~m_ee;                         // R3
        end else if (dc_valid) begin
            if (dc_ex_epoch == m_ee) begin m_pc = dc_target; m_de = ~m_de; end // R6
            // else R7: dropped, nothing changes
        end else if (fp_ready) begin
            m_pc = exp_ppc(m_pc, pred_hit, pred_target);             // R9, R4
        end                                                          // else R11 hold
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240917));
        rst_n = 1'b0;
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        chk("R1 reset pc", fp_pc, RST_PC);
        chk("R1 reset epochs", {fp_ex_epoch, fp_dc_epoch}, 2'b00);
        rst_n = 1'b1;
        m_pc = RST_PC; m_ee = 0; m_de = 0;
        chk("R1 pc after release", fp_pc, RST_PC);
        chk("R1 packet after release", fp_valid, 1);

        // R10: sequential fetch (miss) and predicted fetch (hit)
        drive(0, 0, 0, 0, 0, 0, 0, 0, 1); step();
        chk("R10 pc+4", fp_pc, RST_PC + 4);
        drive(0, 0, 0, 0, 0, 0, 1, 32'h0000_2000, 1); step();
        chk("R9 to predicted", fp_pc, 32'h0000_2000);
        // R11: downstream stall
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0); step();
        chk("R11 hold", fp_pc, 32'h0000_2000);
        // R4: training-only execute message with a fetch
        drive(1, 0, 32'h0000_9000, 0, 0, 0, 0, 0, 1); step();
        chk("R4 no redirect", fp_pc, 32'h0000_2004);
        // R5: execute mispredict and decode correction in the same cycle; decode held
        drive(1, 1, 32'h0000_3000, 1, 0, 32'h0000_5000, 0, 0, 1); step();
        chk("R3 ex redirect pc", fp_pc, 32'h0000_3000);
        chk("R3 ex epoch toggled", fp_ex_epoch, 1);
        // same decode correction now carries a stale tag: dropped (R7)
        drive(0, 0, 0, 1, 0, 32'h0000_5000, 0, 0, 1); step();
        chk("R7 stale dropped", {fp_pc, fp_dc_epoch}, {32'h0000_3000, 1'b0});
        // R6: matching decode correction
        drive(0, 0, 0, 1, 1, 32'h0000_6000, 0, 0, 1); step();
        chk("R6 dc applied", {fp_pc, fp_dc_epoch}, {32'h0000_6000, 1'b1});
        // R4 with decode: training message beside decode correction
        drive(1, 0, 32'h0000_7777, 1, 1, 32'h0000_6100, 0, 0, 1); step();
        chk("R4 dc proceeds", fp_pc, 32'h0000_6100);

        // Constrained random
        for (int i = 0; i < 4000; i++) begin
            drive($urandom_range(0, 3) == 0, $urandom_range(0, 1),
                  $urandom() & 32'hFFFF_FFFC,
                  $urandom_range(0, 3) == 0, $urandom_range(0, 1),
                  $urandom() & 32'hFFFF_FFFC,
                  $urandom_range(0, 1), $urandom() & 32'hFFFF_FFFC,
                  $urandom_range(0, 4) != 0);
            step();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule